// File: doc/BRIEF.md
# Byte-Grouping I2C Target with Word Interface

This block is an I2C target (slave) that runs entirely in the system clock domain. Its SCL and SDA inputs each pass through a two-flop synchronizer. The synchronized lines are compared with their values one cycle earlier to find clock edges and bus conditions. When the address after a START matches the programmed 7-bit identifier, the target acknowledges it and uses the direction bit to choose whether to receive or to send.

In the receive direction, each incoming byte is acknowledged and packed into a word of one, two or three bytes. The first byte on the bus becomes the most significant byte of the word. Each completed word is presented on a parallel output that holds its value until the host takes it. In the send direction, a word is captured from the transmit input at the start of each word and shifted out most significant byte first. The master's acknowledge is sampled after every byte. Four one-cycle interrupt pulses report a received word, a captured transmit word, a receive overrun and a bus error.

The SDA pad is open-drain: `sda_oe` high pulls the line low. Master operation, clock stretching and 10-bit addresses are not part of this block.

Top module: `i2c_word_slave`

## Requirements
- R1: After reset, `sda_oe`, `rx_valid` and all four interrupt outputs are low.
- R2: The target pulls SDA low in the ACK slot of the address byte only when the seven address bits, sent MSB first, equal `slave_id`. On a mismatch it leaves SDA released and ignores all later bytes until the next START.
- R3: The eighth bit of the address byte selects the direction: 0 means the master writes to the target, and 1 means the target sends.
- R4: Data bits are taken MSB first on SCL rising edges. The target pulls SDA low in the ACK slot after every byte it receives, changing SDA only while SCL is low.
- R5: `word_sel` sets the word length: 0 gives one byte, 1 gives two bytes, and 2 or 3 give three bytes. The first byte of a word lands in the most significant byte of the word, and `rx_word` is right-aligned with zeros above the word. When a word completes, `irq_rx` pulses for one cycle and `rx_valid` stays high until `rx_take` is asserted.
- R6: If a word completes while `rx_valid` is high and `rx_take` is low, `irq_ovr` pulses for one cycle, the new word is dropped, and `rx_word` keeps the unread word.
- R7: In the send direction, `tx_word` is captured when the first byte of each word begins and `irq_tx` pulses for one cycle at that moment. The word's bytes go out most significant first, each MSB first.
- R8: A NACK from the master after a sent byte ends the transfer. The target then leaves SDA released until the next START.
- R9: A START or STOP that arrives after the second or later SCL rise of a byte pulses `irq_err`. The target then returns to idle and does not treat that START as the beginning of an address.
- R10: A repeated START at a byte boundary begins a new address phase. Any partly assembled word is discarded on START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line as seen at the pad |
| sda_i | input | 1 | SDA line as seen at the pad |
| sda_oe | output | 1 | High pulls SDA low |
| slave_id | input | 7 | Own 7-bit address |
| word_sel | input | 2 | Bytes per word: 0 one, 1 two, 2/3 three |
| rx_word | output | 24 | Last received word, right-aligned |
| rx_valid | output | 1 | Unread word present in `rx_word` |
| rx_take | input | 1 | Host read strobe; clears `rx_valid` |
| tx_word | input | 24 | Word to send, right-aligned |
| irq_rx | output | 1 | Pulse: word received |
| irq_tx | output | 1 | Pulse: transmit word captured |
| irq_ovr | output | 1 | Pulse: receive overrun |
| irq_err | output | 1 | Pulse: START or STOP inside a byte |

## Verification
The bench drives writes with one-, two- and three-byte words so that byte order and right alignment are both exercised; a byte landing in the wrong lane shows up as a wrong word. It runs a write and a read back to back under one repeated START, and it stops after half a word, which shows whether leftover bytes leak into the next word. It sends an address with the wrong identifier, withholds the read strobe, NACKs partway through a send, and breaks a byte with a STOP and with a START. These cases separate correct address filtering, overrun handling, transfer termination and bus-error recovery from a target that keeps responding.

// File: rtl/i2c_word_slave.sv
module i2c_word_slave (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  input  logic [6:0]  slave_id,
  input  logic [1:0]  word_sel,
  output logic [23:0] rx_word,
  output logic        rx_valid,
  input  logic        rx_take,
  input  logic [23:0] tx_word,
  output logic        irq_rx,
  output logic        irq_tx,
  output logic        irq_ovr,
  output logic        irq_err
);

  typedef enum logic [2:0] {IDLE, ADDR, ACK_OUT, RX, TX, TX_ACK, WAIT} state_t;
  state_t state;

  logic [1:0]  scl_sy, sda_sy;
  logic        scl_q, sda_q;
  logic [3:0]  bitcnt;
  logic [7:0]  shreg;
  logic [1:0]  bytecnt;
  logic        rw;
  logic [23:0] acc, txbuf;
  logic [7:0]  tx_byte;

  wire scl_s    = scl_sy[1];
  wire sda_s    = sda_sy[1];
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_c  = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c   = scl_s & scl_q & ~sda_q & sda_s;
  wire mid_byte = (state inside {ADDR, RX, TX}) && (bitcnt >= 4'd2);
  wire [1:0]  last_b  = (word_sel == 2'd0) ? 2'd0 : (word_sel == 2'd1) ? 2'd1 : 2'd2;
  wire [1:0]  lane    = last_b - bytecnt;
  wire [23:0] tx_src  = (bytecnt == 2'd0) ? tx_word : txbuf;
  wire [23:0] acc_nxt = (bytecnt == 2'd0) ? {16'h0, shreg} : {acc[15:0], shreg};

  always_comb
    case (lane)
      2'd2:    tx_byte = tx_src[23:16];
      2'd1:    tx_byte = tx_src[15:8];
      default: tx_byte = tx_src[7:0];
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state    <= IDLE;
      sda_oe   <= 1'b0;
      bitcnt   <= '0;
      shreg    <= '0;
      bytecnt  <= '0;
      rw       <= 1'b0;
      acc      <= '0;
      txbuf    <= '0;
      rx_word  <= '0;
      rx_valid <= 1'b0;
      irq_rx   <= 1'b0;
      irq_tx   <= 1'b0;
      irq_ovr  <= 1'b0;
      irq_err  <= 1'b0;
    end else begin
      irq_rx  <= 1'b0;
      irq_tx  <= 1'b0;
      irq_ovr <= 1'b0;
      irq_err <= 1'b0;
      if (rx_take) rx_valid <= 1'b0;
      if ((start_c || stop_c) && mid_byte) begin
        irq_err <= 1'b1;
        state   <= IDLE;
        sda_oe  <= 1'b0;
      end else if (start_c) begin
        state   <= ADDR;
        bitcnt  <= '0;
        bytecnt <= '0;
        sda_oe  <= 1'b0;
      end else if (stop_c) begin
        state  <= IDLE;
        sda_oe <= 1'b0;
      end else
        case (state)
          ADDR, RX:
            if (scl_rise && bitcnt < 4'd8) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              if (state == ADDR) begin
                if (shreg[7:1] == slave_id) begin
                  rw     <= shreg[0];
                  sda_oe <= 1'b1;
                  state  <= ACK_OUT;
                end else
                  state <= WAIT;
              end else begin
                sda_oe <= 1'b1;
                state  <= ACK_OUT;
                acc    <= acc_nxt;
                if (bytecnt >= last_b) begin
                  bytecnt <= '0;
                  if (rx_valid && !rx_take)
                    irq_ovr <= 1'b1;
                  else begin
                    rx_word  <= acc_nxt;
                    rx_valid <= 1'b1;
                    irq_rx   <= 1'b1;
                  end
                end else
                  bytecnt <= bytecnt + 2'd1;
              end
            end
          ACK_OUT, TX_ACK:
            if (state == TX_ACK && scl_rise) begin
              if (sda_s) state <= WAIT;
              else bitcnt <= 4'd9;
            end else if (scl_fall && (state == ACK_OUT || bitcnt == 4'd9)) begin
              bitcnt <= '0;
              sda_oe <= 1'b0;
              if (!rw)
                state <= RX;
              else begin
                state  <= TX;
                shreg  <= tx_byte;
                sda_oe <= ~tx_byte[7];
                if (bytecnt == 2'd0) begin
                  txbuf  <= tx_word;
                  irq_tx <= 1'b1;
                end
              end
            end
          TX:
            if (scl_rise && bitcnt < 4'd8)
              bitcnt <= bitcnt + 4'd1;
            else if (scl_fall && bitcnt != 4'd0) begin
              if (bitcnt == 4'd8) begin
                sda_oe  <= 1'b0;
                state   <= TX_ACK;
                bytecnt <= (bytecnt >= last_b) ? 2'd0 : bytecnt + 2'd1;
              end else begin
                shreg  <= {shreg[6:0], 1'b0};
                sda_oe <= ~shreg[6];
              end
            end
          default: ;
        endcase
    end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == IDLE || state == WAIT) |-> !sda_oe);
  // R4
  oe_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !$past(scl_s));
  // R5
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> irq_rx);
  // R6
  ovr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_rx && irq_ovr));
  // R7
  tx_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx |-> (rw && state == TX));
  // R9
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |-> state == IDLE);

endmodule

// File: tb/i2c_word_slave_bench.sv
module i2c_word_slave_bench;
  localparam int Q  = 10;
  localparam logic [6:0] ID = 7'h2A;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0]  word_sel = 2'd0;
  logic [23:0] tx_word = '0;
  logic        rx_take = 1'b0;
  logic        sda_oe, rx_valid, irq_rx, irq_tx, irq_ovr, irq_err;
  logic [23:0] rx_word;
  wire sda_line = sda_m & ~sda_oe;

  i2c_word_slave u_i2c_word_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .slave_id(ID), .word_sel(word_sel), .rx_word(rx_word), .rx_valid(rx_valid),
    .rx_take(rx_take), .tx_word(tx_word), .irq_rx(irq_rx), .irq_tx(irq_tx),
    .irq_ovr(irq_ovr), .irq_err(irq_err));

  int checks = 0, fails = 0;
  int n_rx = 0, n_tx = 0, n_ovr = 0, n_err = 0;
  logic [23:0] exp_q[$];
  logic auto_take = 1'b1;
  logic done = 1'b0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start;
    sda_m = 1; step(Q); scl_m = 1; step(Q); sda_m = 0; step(Q); scl_m = 0; step(Q);
  endtask
  task automatic bus_stop;
    sda_m = 0; step(Q); scl_m = 1; step(Q); sda_m = 1; step(Q);
  endtask
  task automatic wbit(logic b);
    sda_m = b; step(Q); scl_m = 1; step(2*Q); scl_m = 0; step(Q);
  endtask
  task automatic rbit(output logic b);
    sda_m = 1; step(Q); scl_m = 1; step(Q); b = sda_line; step(Q); scl_m = 0; step(Q);
  endtask
  task automatic wbyte(logic [7:0] d, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(a);
    acked = !a;
  endtask
  task automatic rbyte(output logic [7:0] d, input logic ack_m);
    logic b;
    for (int i = 7; i >= 0; i--) begin rbit(b); d[i] = b; end
    wbit(!ack_m);
  endtask

  // per-clock reference comparison of the interrupt stream
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (irq_rx) begin
        n_rx++;
        if (exp_q.size() == 0) chk("R5 unexpected irq_rx", 1, 0);
        else chk("R5 rx_word", rx_word, exp_q.pop_front());
      end
      if (irq_tx)  n_tx++;
      if (irq_ovr) n_ovr++;
      if (irq_err) n_err++;
      rx_take = auto_take && rx_valid;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic ak;
    logic [7:0] b;
    int base;
    step(4); rst_n = 1; step(2);
    // R1
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 irqs", {irq_rx, irq_tx, irq_ovr, irq_err}, 0);

    // R2 R4 R5 one-byte words
    word_sel = 2'd0;
    bus_start; wbyte({ID, 1'b0}, ak); chk("R2 address ack", ak, 1);
    exp_q.push_back(24'h00003C); wbyte(8'h3C, ak); chk("R4 data ack", ak, 1);
    exp_q.push_back(24'h000081); wbyte(8'h81, ak); chk("R4 data ack", ak, 1);
    bus_stop; step(4);
    chk("R5 one-byte words drained", exp_q.size(), 0);

    // R5 three-byte word
    word_sel = 2'd2; base = n_rx;
    bus_start; wbyte({ID, 1'b0}, ak);
    exp_q.push_back(24'h112233);
    wbyte(8'h11, ak); wbyte(8'h22, ak); wbyte(8'h33, ak);
    bus_stop; step(4);
    chk("R5 three-byte word count", n_rx - base, 1);

    // R10 partial word discarded, R5 two-byte word
    word_sel = 2'd1; base = n_rx;
    bus_start; wbyte({ID, 1'b0}, ak); wbyte(8'hAB, ak); bus_stop;
    bus_start; wbyte({ID, 1'b0}, ak);
    exp_q.push_back(24'h00BEEF);
    wbyte(8'hBE, ak); wbyte(8'hEF, ak); bus_stop; step(4);
    chk("R10 partial word dropped", n_rx - base, 1);

    // R2 mismatch
    base = n_rx;
    bus_start; wbyte({7'h15, 1'b0}, ak); chk("R2 mismatch nack", ak, 0);
    wbyte(8'h55, ak); chk("R2 bytes ignored", ak, 0);
    bus_stop; step(4);
    chk("R2 no word on mismatch", n_rx - base, 0);

    // R6 overrun
    word_sel = 2'd0; auto_take = 0; base = n_ovr;
    bus_start; wbyte({ID, 1'b0}, ak);
    exp_q.push_back(24'h00005A);
    wbyte(8'h5A, ak); wbyte(8'hC3, ak); bus_stop; step(4);
    chk("R6 overrun irq", n_ovr - base, 1);
    chk("R6 old word kept", rx_word, 24'h00005A);
    chk("R6 still valid", rx_valid, 1);
    auto_take = 1; step(4);
    chk("R5 rx_take clears", rx_valid, 0);

    // R3 R7 send, R8 NACK
    word_sel = 2'd1; tx_word = 24'h00A55A; base = n_tx;
    bus_start; wbyte({ID, 1'b1}, ak); chk("R3 read address ack", ak, 1);
    rbyte(b, 1); chk("R7 byte0", b, 8'hA5);
    tx_word = 24'h001234;
    rbyte(b, 1); chk("R7 byte1", b, 8'h5A);
    rbyte(b, 0); chk("R7 next word byte0", b, 8'h12);
    chk("R7 irq_tx count", n_tx - base, 2);
    rbyte(b, 0); chk("R8 released after NACK", b, 8'hFF);
    bus_stop; step(4);

    // R10 repeated START, write then read
    word_sel = 2'd0; base = n_rx;
    bus_start; wbyte({ID, 1'b0}, ak);
    exp_q.push_back(24'h000077); wbyte(8'h77, ak);
    tx_word = 24'h0000C6;
    bus_start; wbyte({ID, 1'b1}, ak); chk("R10 repeated start ack", ak, 1);
    rbyte(b, 0); chk("R10 read after repeated start", b, 8'hC6);
    bus_stop; step(4);
    chk("R10 write before repeated start", n_rx - base, 1);

    // R9 STOP inside byte
    base = n_err;
    bus_start; wbit(1); wbit(0); wbit(1); bus_stop; step(4);
    chk("R9 stop mid-byte", n_err - base, 1);
    bus_start; wbyte({ID, 1'b0}, ak); chk("R9 recovered", ak, 1);
    // R9 START inside byte
    wbit(1); wbit(1); bus_start; step(2);
    chk("R9 start mid-byte", n_err - base, 2);
    wbyte({ID, 1'b0}, ak); chk("R9 address after bad start ignored", ak, 0);
    bus_stop; step(4);
    chk("R5 queue empty", exp_q.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule